// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block turns a 32 MHz reference clock into one of eight output frequencies for an external pin. A 3-bit divide code picks the ratio. An enable field starts and stops the output, and a run-on field chooses between two ways of stopping: stop at the next low point, or keep pulsing for a fixed count first. The code loaded at reset depends on a strap pin. A pad drive-strength bit is stored and passed straight out.

Configuration arrives through a single write strobe that captures all four fields on one reference edge. A frequency change waits for the end of a low phase, so no pulse is ever cut short. The output always comes to rest low. For the divide-by-one code, the output is the reference clock passed through a gate that is updated on the falling edge. Every other code drives the output from a toggling flop.

The sequencer has four states. `ST_OFF`: no output. `ST_RUN`: normal output. `ST_DRAIN`: run-on pulses after a disable. `ST_STOP`: the current high phase finishes, then the output stops. The transitions are:
- `ST_OFF` to `ST_RUN` when enabled.
- `ST_RUN` to `ST_DRAIN` on disable with run-on set.
- `ST_RUN` to `ST_STOP` on disable without run-on.
- `ST_DRAIN` to `ST_STOP` on the last run-on pulse.
- `ST_DRAIN` or `ST_STOP` back to `ST_RUN` when re-enabled.
- `ST_STOP` to `ST_OFF` once the output is idle and low.

Top module: `clkout_gen`

## Requirements
- R1: The output period, in reference cycles, for divide code 0..7 is 1, 2, 4, 8, 16, 32, 512 and 976.
- R2: For codes 1..7 the output is high for exactly half the period. For code 0 it is high during the high half of the reference clock.
- R3: At reset the divide code becomes 3 if `strap_slow` is low and 7 if it is high. At reset, enable becomes 1, run-on becomes 0 and drive becomes 0.
- R4: While disabled and stopped, the output stays low and shows no rising edge.
- R5: On disable with run-on set, exactly 128 output rising edges occur, counted from the first reference edge that sees the disable (that edge included). The output then stops low.
- R6: On disable with run-on clear and a divide code other than 0, no rising edge occurs from the first reference edge that sees the disable onward. The output is low within one half period.
- R7: Re-enabling during run-on clears the run-on count, so a later disable again yields exactly 128 rising edges.
- R8: A new divide code is adopted only at the end of a low phase. Every high phase lasts either the old code's high time or the new code's high time.
- R9: `clk_active` is 0 after reset and whenever the output has fully stopped. It is 1 while pulses are produced, including during run-on.
- R10: `pad_drive` equals the `cfg_drive` value captured by the last `cfg_we` strobe, from the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_slow | input | 1 | Strap selecting the reset divide code (0: code 3, 1: code 7) |
| cfg_we | input | 1 | Write strobe capturing the four configuration fields |
| cfg_div | input | 3 | Divide code |
| cfg_enable | input | 1 | Output enable |
| cfg_runon | input | 1 | 1: keep pulsing 128 times after disable |
| cfg_drive | input | 1 | Pad drive strength bit |
| clk_out | output | 1 | Divided clock output |
| pad_drive | output | 1 | Stored drive strength bit |
| clk_active | output | 1 | High while the output is running or draining |

## Verification
Fields written on edge R are seen by the sequencer on edge R+1. From that edge, the divided codes change the output in the same cycle, and code 0 changes it half a cycle later through the falling-edge gate. The bench starts counting output rising edges one time unit after edge R, so the first counted edge is exactly the first one the design attributes to the disable. Periods and high times are measured between output edges only after three full pulses at the new code, so that the switchover pulse is never mistaken for steady state. Stop checks wait longer than one half period of the slowest code in use.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
    localparam int SEL_W       = 3;
    localparam int CNT_W       = 9;
    localparam int DIV_SLOW    = 512;
    localparam int DIV_SLOWEST = 976;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_DRAIN,
        ST_STOP
    } seq_state_e;

    // Last count of one half period, in reference cycles, for a divide code.
    function automatic logic [CNT_W-1:0] half_last(input sel_t code);
        logic [CNT_W-1:0] r;
        if (code == sel_t'(7))
            r = CNT_W'(DIV_SLOWEST / 2 - 1);
        else if (code == sel_t'(6))
            r = CNT_W'(DIV_SLOW / 2 - 1);
        else if (code == '0)
            r = '0;
        else
            r = CNT_W'((32'd1 << (int'(code) - 1)) - 32'd1);
        return r;
    endfunction
endpackage

// File: rtl/clkout_cfg_regs.sv
`timescale 1ns/1ps
module clkout_cfg_regs
    import clkout_pkg::*;
#(
    parameter int W = SEL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap_slow,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_div,
    input  logic         cfg_enable,
    input  logic         cfg_runon,
    input  logic         cfg_drive,
    output logic [W-1:0] div_q,
    output logic         en_q,
    output logic         runon_q,
    output logic         drive_q
);
    localparam logic [W-1:0] CODE_FAST_DEF = W'(3);
    localparam logic [W-1:0] CODE_SLOW_DEF = W'(7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= strap_slow ? CODE_SLOW_DEF : CODE_FAST_DEF;
            en_q    <= 1'b1;
            runon_q <= 1'b0;
            drive_q <= 1'b0;
        end else if (cfg_we) begin
            div_q   <= cfg_div;
            en_q    <= cfg_enable;
            runon_q <= cfg_runon;
            drive_q <= cfg_drive;
        end
    end

    // R10
    drive_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (drive_q == $past(cfg_drive)));
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider
    import clkout_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic load_ok,
    input  sel_t sel_next,
    input  logic gate_q,
    output logic q,
    output logic gate_req,
    output logic rise_cand,
    output logic stopped,
    output logic is_div1
);
    sel_t          active_q;
    logic [CW-1:0] cnt_q;
    logic          q_r;
    logic          greq_r;
    logic          live_q;

    logic [CW-1:0] last_w;
    logic          div1_w;
    logic          low_end_w;
    logic          hi_end_w;
    logic          bnd_w;
    sel_t          pick_w;

    always_comb begin
        last_w    = CW'(half_last(active_q));
        div1_w    = (active_q == '0);
        low_end_w = live_q && !div1_w && !q_r && (cnt_q == last_w);
        hi_end_w  = q_r && (cnt_q == last_w);
        bnd_w     = div1_w ? greq_r : low_end_w;
        pick_w    = load_ok ? sel_next : active_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
            cnt_q    <= '0;
            q_r      <= 1'b0;
            greq_r   <= 1'b0;
            live_q   <= 1'b0;
        end else if (!run) begin
            greq_r <= 1'b0;
            live_q <= q_r && !hi_end_w;
            if (hi_end_w) begin
                q_r   <= 1'b0;
                cnt_q <= '0;
            end else if (q_r) begin
                cnt_q <= cnt_q + CW'(1);
            end else begin
                cnt_q <= '0;
            end
        end else if (!live_q) begin
            live_q   <= 1'b1;
            active_q <= sel_next;
            cnt_q    <= '0;
            if (sel_next == '0) greq_r <= 1'b1;
            else                q_r    <= 1'b1;
        end else if (bnd_w) begin
            active_q <= pick_w;
            cnt_q    <= '0;
            if (pick_w == '0) begin
                greq_r <= 1'b1;
                q_r    <= 1'b0;
            end else begin
                greq_r <= 1'b0;
                q_r    <= 1'b1;
            end
        end else if (hi_end_w) begin
            q_r   <= 1'b0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign q         = q_r;
    assign gate_req  = greq_r;
    assign rise_cand = gate_q || low_end_w;
    assign stopped   = !live_q && !q_r && !greq_r && !gate_q;
    assign is_div1   = div1_w;

    // R8
    sel_switch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q != $past(active_q)) |-> !$past(q_r));

    // R6
    no_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !q_r) |=> !q_r);
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    input  logic q,
    output logic gate_q,
    output logic clk_out
);
    // Updated while the reference is low, so the AND below never chops a pulse.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_req;
    end

    assign clk_out = (clk && gate_q) || q;
endmodule

// File: rtl/clkout_seq_fsm.sv
`timescale 1ns/1ps
module clkout_seq_fsm
    import clkout_pkg::*;
#(
    parameter int RUNON_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic runon,
    input  logic is_div1,
    input  logic rise_cand,
    input  logic stopped,
    output logic run,
    output logic load_ok,
    output logic running
);
    localparam int DW = (RUNON_CYCLES > 1) ? $clog2(RUNON_CYCLES) : 1;
    localparam logic [DW-1:0] LAST_RISE = DW'(RUNON_CYCLES - 1);

    seq_state_e    state_q, state_d;
    logic [DW-1:0] drain_q, drain_d;
    logic          drain_edge;
    logic [DW-1:0] base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            drain_q <= '0;
        end else begin
            state_q <= state_d;
            drain_q <= drain_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        drain_d    = '0;
        run        = 1'b0;
        load_ok    = 1'b0;
        drain_edge = 1'b0;
        base       = '0;
        unique case (state_q)
            ST_OFF: begin
                if (en) begin
                    state_d = ST_RUN;
                    run     = 1'b1;
                    load_ok = 1'b1;
                end
            end
            ST_RUN: begin
                if (en) begin
                    run     = 1'b1;
                    load_ok = 1'b1;
                end else if (runon) begin
                    state_d    = ST_DRAIN;
                    drain_edge = 1'b1;
                end else begin
                    state_d = ST_STOP;
                end
            end
            ST_DRAIN: begin
                if (en) begin
                    state_d = ST_RUN;
                    run     = 1'b1;
                    load_ok = 1'b1;
                end else begin
                    drain_edge = 1'b1;
                    base       = drain_q;
                end
            end
            ST_STOP: begin
                if (en) begin
                    state_d = ST_RUN;
                    run     = 1'b1;
                    load_ok = 1'b1;
                end else if (stopped) begin
                    state_d = ST_OFF;
                end
            end
        endcase
        if (drain_edge) begin
            if (rise_cand && (base == LAST_RISE)) begin
                run     = !is_div1;
                state_d = ST_STOP;
            end else begin
                run     = 1'b1;
                drain_d = base + DW'(rise_cand);
            end
        end
        running = (state_q != ST_OFF);
    end

    // R4
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> stopped);

    // R7
    reenable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && en) |=> (state_q == ST_RUN && drain_q == '0));
endmodule

// File: rtl/clkout_gen.sv
`timescale 1ns/1ps
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int RUNON_CYCLES = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_slow,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_div,
    input  logic             cfg_enable,
    input  logic             cfg_runon,
    input  logic             cfg_drive,
    output logic             clk_out,
    output logic             pad_drive,
    output logic             clk_active
);
    sel_t div_w;
    logic en_w, runon_w;
    logic run_w, load_w, running_w;
    logic q_w, greq_w, gate_w, rise_w, stop_w, div1_w;

    clkout_cfg_regs #(.W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_slow (strap_slow),
        .cfg_we     (cfg_we),
        .cfg_div    (cfg_div),
        .cfg_enable (cfg_enable),
        .cfg_runon  (cfg_runon),
        .cfg_drive  (cfg_drive),
        .div_q      (div_w),
        .en_q       (en_w),
        .runon_q    (runon_w),
        .drive_q    (pad_drive)
    );

    clkout_seq_fsm #(.RUNON_CYCLES(RUNON_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_w),
        .runon     (runon_w),
        .is_div1   (div1_w),
        .rise_cand (rise_w),
        .stopped   (stop_w),
        .run       (run_w),
        .load_ok   (load_w),
        .running   (running_w)
    );

    clkout_divider #(.CW(CNT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .load_ok   (load_w),
        .sel_next  (div_w),
        .gate_q    (gate_w),
        .q         (q_w),
        .gate_req  (greq_w),
        .rise_cand (rise_w),
        .stopped   (stop_w),
        .is_div1   (div1_w)
    );

    clkout_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_req (greq_w),
        .q        (q_w),
        .gate_q   (gate_w),
        .clk_out  (clk_out)
    );

    assign clk_active = running_w;

    // R9
    status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_w |-> (!q_w && !gate_w));
endmodule

// File: tb/clkout_gen_tb.sv
`timescale 1ns/1ps
module clkout_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic       we = 1'b0;
    logic [2:0] dv = '0;
    logic       en = 1'b0, ro = 1'b0, drv = 1'b0;
    wire        clk_out, pad_drive, clk_active;

    int n_chk = 0;
    int n_err = 0;
    longint t_rise = 0, last_per = 0, last_hw = 0;
    int  rise_cnt = 0;
    logic counting = 1'b0;

    clkout_gen u_dut (
        .clk (clk), .rst_n (rst_n), .strap_slow (strap), .cfg_we (we),
        .cfg_div (dv), .cfg_enable (en), .cfg_runon (ro), .cfg_drive (drv),
        .clk_out (clk_out), .pad_drive (pad_drive), .clk_active (clk_active)
    );

    always #(HALF) clk = ~clk;

    always @(posedge clk_out) begin
        last_per = longint'($time) - t_rise;
        t_rise   = longint'($time);
        if (counting) rise_cnt++;
    end
    always @(negedge clk_out) last_hw = longint'($time) - t_rise;

    function automatic longint ratio(input int s);
        if (s == 7) return 976;
        if (s == 6) return 512;
        return longint'(1) << s;
    endfunction
    function automatic longint hi_time(input int s);
        return (s == 0) ? HALF : ratio(s) / 2 * CLK_PERIOD;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic wr(input int s, input logic e, input logic r, input logic d);
        @(posedge clk); #1;
        dv = 3'(s); en = e; ro = r; drv = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic measure(input int s);
        repeat (3) @(negedge clk_out);
        #1;
        check("R1 period", last_per, ratio(s) * CLK_PERIOD);
        check("R2 high time", last_hw, hi_time(s));
    endtask

    task automatic wait_stop();
        for (int g = 0; g < 20000 && clk_active; g++) @(negedge clk);
    endtask

    task automatic drain_run(input int s);
        wr(s, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk_out);
        wr(s, 1'b0, 1'b1, 1'b0);
        rise_cnt = 0; counting = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 active during run-on", longint'(clk_active), 1);
        wait_stop();
        repeat (2) @(negedge clk);
        counting = 1'b0;
        check("R5 run-on rising edges", rise_cnt, 128);
        check("R5 output rests low", longint'(clk_out), 0);
        check("R9 inactive after stop", longint'(clk_active), 0);
    endtask

    initial begin
        #(longint'(CLK_PERIOD) * 190000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // reset with strap low
        repeat (3) @(posedge clk);
        #1;
        check("R9 inactive in reset", longint'(clk_active), 0);
        check("R3 drive reset", longint'(pad_drive), 0);
        check("R4 output low in reset", longint'(clk_out), 0);
        rst_n = 1'b1;
        measure(3);
        check("R9 active when running", longint'(clk_active), 1);

        // R1 R2 sweep over all codes
        for (int s = 0; s < 8; s++) begin
            wr(s, 1'b1, 1'b0, 1'b0);
            measure(s);
        end

        // R8 switching between codes
        begin
            int pa[5] = '{7, 2, 0, 5, 3};
            int pb[5] = '{2, 7, 5, 0, 6};
            for (int k = 0; k < 5; k++) begin
                wr(pa[k], 1'b1, 1'b0, 1'b0);
                repeat (3) @(negedge clk_out);
                wr(pb[k], 1'b1, 1'b0, 1'b0);
                for (int j = 0; j < 4; j++) begin
                    @(negedge clk_out); #1;
                    check("R8 high phase width", last_hw,
                          (last_hw == hi_time(pb[k])) ? hi_time(pb[k]) : hi_time(pa[k]));
                end
            end
        end

        // R6 stop without run-on
        for (int k = 0; k < 2; k++) begin
            int s;
            s = (k == 0) ? 3 : 5;
            wr(s, 1'b1, 1'b0, 1'b0);
            measure(s);
            wr(s, 1'b0, 1'b0, 1'b0);
            rise_cnt = 0; counting = 1'b1;
            repeat (int'(ratio(s)) / 2 + 3) @(negedge clk);
            check("R6 no rise after disable", rise_cnt, 0);
            check("R6 output low", longint'(clk_out), 0);
            check("R9 inactive after stop", longint'(clk_active), 0);
            // R4 quiet while disabled
            repeat (100) @(negedge clk);
            counting = 1'b0;
            check("R4 no pulses while disabled", rise_cnt, 0);
        end

        // R5 run-on counts
        drain_run(0);
        drain_run(2);
        drain_run(5);

        // R7 re-enable during run-on clears the count
        wr(2, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk_out);
        wr(2, 1'b0, 1'b1, 1'b0);
        repeat (40) @(negedge clk_out);
        wr(2, 1'b1, 1'b1, 1'b0);
        measure(2);
        check("R7 active after re-enable", longint'(clk_active), 1);
        wr(2, 1'b0, 1'b1, 1'b0);
        rise_cnt = 0; counting = 1'b1;
        wait_stop();
        repeat (2) @(negedge clk);
        counting = 1'b0;
        check("R7 full run-on after re-enable", rise_cnt, 128);

        // R10 drive pass-through
        wr(2, 1'b1, 1'b0, 1'b1);
        check("R10 drive set", longint'(pad_drive), 1);
        wr(2, 1'b1, 1'b0, 1'b0);
        check("R10 drive clear", longint'(pad_drive), 0);

        // R3 strap high default
        @(posedge clk); #1;
        rst_n = 1'b0; strap = 1'b1;
        repeat (2) @(posedge clk); #1;
        check("R3 drive reset", longint'(pad_drive), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_out);
        #1;
        check("R3 strap high period", last_per, 976 * CLK_PERIOD);
        check("R3 strap high high time", last_hw, 488 * CLK_PERIOD);

        finish_run();
    end
endmodule